// File: doc/BRIEF.md
# VCO Output Clock Divider

This block takes the fast oscillator clock and produces the output clock through a chosen division path. The four choices are a straight pass-through, a fixed halving, a fixed quartering, and a programmable even divider that covers /4 to /30 in steps of two. A 3-bit path code picks the path. Its top bit places an extra halving stage ahead of whichever path the lower two bits choose. A 4-bit ratio code sets the programmable divider.

A disable input forces the output low. Two ratio codes have no meaning and also park the output low. Every divided setting gives a 50% duty cycle, counted in oscillator cycles.

A new setting never cuts a pulse short. While the output is toggling, a new setting is taken up only on the edge where the output falls. While the output is parked low, a new setting is taken up on the next clock edge. The pass-through path goes through a gate whose enable changes only while the oscillator clock is low.

Top module: `vco_out_divider`

## Requirements
- R1: With path code 000 and the disable input low, the output is the oscillator clock: period of one cycle, high for half a cycle.
- R2: Path code 001 divides by 2 and path code 010 divides by 4. The ratio code has no effect on either.
- R3: Path code 011 with ratio code k from 1 to 14 divides by 2k+2. For example, ratio code 0010 gives /6 and 1110 gives /30.
- R4: Setting path code bit 2 doubles the ratio chosen by bits 1:0. Code 100 gives /2, 101 gives /4, 110 gives /8, and 111 with ratio code k gives /(4k+4).
- R5: For every divided setting of total ratio D, the output stays high for exactly D/2 oscillator cycles and low for exactly D/2 cycles.
- R6: Path code x11 with ratio code 0000 or 1111 holds the output low, with no rising edge.
- R7: With the disable input high, the output stays low whatever the path and ratio codes are.
- R8: A change of setting while the output is toggling takes effect at the next falling edge of the output. The high phase in progress completes with the old ratio, and the low phase that follows uses the new ratio.
- R9: While reset is asserted the output is low.
- R10: When the output is parked low, a new divided setting is taken at the next clock edge. The first rising edge comes D/2 cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco_i | input | 1 | Fast oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| path_sel_i | input | 3 | Path code: bit 2 adds a halving stage; bits 1:0 select direct, /2, /4 or programmable |
| ratio_code_i | input | CODE_W | Programmable divider code (ratio 2k+2) |
| out_off_i | input | 1 | Forces the output low |
| clk_div_o | output | 1 | Divided output clock |

## Verification
The checker assumes that the path code, the ratio code and the disable input change only just after a rising oscillator edge. It also assumes they settle well inside one cycle, so each value is seen whole at a single edge. The stimulus changes them only one nanosecond after a rising edge and holds them steady for at least several output periods. Pulse-length properties count sampled cycles, so they rely on a setting being taken up only on the output's falling edge or while the output is parked low. The sweep therefore gives every setting time to take effect before it measures the period and the high time, whatever state the previous setting left behind.

// File: rtl/odiv_pkg.sv
package odiv_pkg;
  typedef enum logic [1:0] {
    M_IDLE   = 2'd0,
    M_DIRECT = 2'd1,
    M_DIV    = 2'd2
  } mode_e;
endpackage

// File: rtl/odiv_decode.sv
module odiv_decode #(
  parameter int CODE_W = 4,
  parameter int HALF_W = 5
) (
  input  logic [2:0]        path_sel_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              off_i,
  output odiv_pkg::mode_e   mode_o,
  output logic [HALF_W-1:0] half_o
);
  import odiv_pkg::*;
  localparam int DW = HALF_W + 1;

  logic [DW-1:0] base_ratio;
  logic [DW-1:0] total_ratio;
  logic          code_bad;

  always_comb begin
    code_bad   = 1'b0;
    base_ratio = DW'(1);
    unique case (path_sel_i[1:0])
      2'b00: base_ratio = DW'(1);
      2'b01: base_ratio = DW'(2);
      2'b10: base_ratio = DW'(4);
      default: begin
        base_ratio = DW'({ratio_code_i, 1'b0}) + DW'(2);
        code_bad   = (ratio_code_i == '0) || (ratio_code_i == '1);
      end
    endcase
    total_ratio = path_sel_i[2] ? (base_ratio << 1) : base_ratio;
  end

  always_comb begin
    half_o = total_ratio[DW-1:1];
    if (off_i || code_bad) begin
      mode_o = M_IDLE;
      half_o = HALF_W'(1);
    end else if (total_ratio == DW'(1)) begin
      mode_o = M_DIRECT;
      half_o = HALF_W'(1);
    end else begin
      mode_o = M_DIV;
    end
  end
endmodule

// File: rtl/odiv_ctrl.sv
module odiv_ctrl #(
  parameter int HALF_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  odiv_pkg::mode_e   mode_d_i,
  input  logic [HALF_W-1:0] half_d_i,
  output odiv_pkg::mode_e   mode_q_o,
  output logic [HALF_W-1:0] half_q_o
);
  import odiv_pkg::*;

  mode_e             mode_nxt;
  logic [HALF_W-1:0] half_nxt;

  always_comb begin
    mode_nxt = mode_q_o;
    half_nxt = half_q_o;
    if (load_en_i) begin
      mode_nxt = mode_d_i;
      half_nxt = half_d_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q_o <= M_IDLE;
      half_q_o <= HALF_W'(1);
    end else begin
      mode_q_o <= mode_nxt;
      half_q_o <= half_nxt;
    end
  end
endmodule

// File: rtl/odiv_count.sv
module odiv_count #(
  parameter int HALF_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  odiv_pkg::mode_e   mode_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              load_en_o,
  output logic [HALF_W-1:0] cnt_o,
  output logic              q_o
);
  import odiv_pkg::*;

  logic              at_term;
  logic              run_en;
  logic [HALF_W-1:0] cnt_nxt;
  logic              q_nxt;

  assign run_en    = (mode_i == M_DIV);
  assign at_term   = (cnt_o == half_i - HALF_W'(1));
  assign load_en_o = !run_en || (q_o && at_term);

  always_comb begin
    cnt_nxt = cnt_o;
    q_nxt   = q_o;
    if (load_en_o) begin
      cnt_nxt = '0;
      q_nxt   = 1'b0;
    end else if (run_en) begin
      if (at_term) begin
        cnt_nxt = '0;
        q_nxt   = !q_o;
      end else begin
        cnt_nxt = cnt_o + HALF_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      q_o   <= 1'b0;
    end else begin
      cnt_o <= cnt_nxt;
      q_o   <= q_nxt;
    end
  end
endmodule

// File: rtl/vco_out_divider.sv
module vco_out_divider #(
  parameter int CODE_W = 4
) (
  input  logic              clk_vco_i,
  input  logic              rst_ni,
  input  logic [2:0]        path_sel_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  input  logic              out_off_i,
  output logic              clk_div_o
);
  import odiv_pkg::*;
  localparam int MAX_DIV = 2 * (2 * ((1 << CODE_W) - 2) + 2);
  localparam int HALF_W  = $clog2(MAX_DIV / 2 + 1);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  mode_e             dec_mode;
  logic [HALF_W-1:0] dec_half;
  mode_e             act_mode;
  logic [HALF_W-1:0] act_half;
  logic              load_en;
  logic [HALF_W-1:0] div_cnt;
  logic              div_q;
  logic              dir_gate;

  always_ff @(posedge clk_vco_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe <= 2'b00;
    else         rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  odiv_decode #(.CODE_W(CODE_W), .HALF_W(HALF_W)) u_decode (
    .path_sel_i   (path_sel_i),
    .ratio_code_i (ratio_code_i),
    .off_i        (out_off_i),
    .mode_o       (dec_mode),
    .half_o       (dec_half)
  );

  odiv_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk_i     (clk_vco_i),
    .rst_ni    (rst_sync_n),
    .load_en_i (load_en),
    .mode_d_i  (dec_mode),
    .half_d_i  (dec_half),
    .mode_q_o  (act_mode),
    .half_q_o  (act_half)
  );

  odiv_count #(.HALF_W(HALF_W)) u_count (
    .clk_i     (clk_vco_i),
    .rst_ni    (rst_sync_n),
    .mode_i    (act_mode),
    .half_i    (act_half),
    .load_en_o (load_en),
    .cnt_o     (div_cnt),
    .q_o       (div_q)
  );

  always_ff @(negedge clk_vco_i or negedge rst_sync_n) begin
    if (!rst_sync_n) dir_gate <= 1'b0;
    else             dir_gate <= (act_mode == M_DIRECT);
  end

  assign clk_div_o = div_q | (dir_gate & clk_vco_i);
endmodule

// File: rtl/vco_out_divider_chk.sv
module vco_out_divider_chk #(
  parameter int HALF_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input odiv_pkg::mode_e   mode_i,
  input logic [HALF_W-1:0] half_i,
  input logic [HALF_W-1:0] cnt_i,
  input logic              q_i,
  input logic              gate_i
);
  import odiv_pkg::*;

  logic [HALF_W:0] hi_len;
  logic [HALF_W:0] lo_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= '0;
      lo_len <= '0;
    end else begin
      hi_len <= q_i ? hi_len + 1'b1 : '0;
      if (q_i)           lo_len <= '0;
      else if (!(&lo_len)) lo_len <= lo_len + 1'b1;
    end
  end

  p_gate_on_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_DIRECT) |-> gate_i);
  p_gate_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != M_DIRECT) |-> !gate_i);
  p_gate_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_i |-> !q_i);
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_DIV) |-> (cnt_i < half_i));
  p_high_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_i) |-> (hi_len == {1'b0, $past(half_i)}));
  p_low_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_i) |-> (lo_len >= {1'b0, $past(half_i)}));
  p_idle_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_IDLE) |-> !q_i);
  p_switch_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode_i, half_i}) |-> !q_i);
endmodule

bind vco_out_divider vco_out_divider_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i  (clk_vco_i),
  .rst_ni (rst_sync_n),
  .mode_i (act_mode),
  .half_i (act_half),
  .cnt_i  (div_cnt),
  .q_i    (div_q),
  .gate_i (dir_gate)
);

// File: tb/vco_out_divider_bench.sv
`timescale 1ns/1ps
module vco_out_divider_bench;
  localparam real TCK = 5.0;

  logic       clk;
  logic       rst_n;
  logic [2:0] sel;
  logic [3:0] code;
  logic       off;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  int nrise  = 0;
  int nfall  = 0;
  realtime rt_last = 0.0;
  realtime per_last = 0.0;
  realtime hi_last = 0.0;

  vco_out_divider u_vco_out_divider (
    .clk_vco_i    (clk),
    .rst_ni       (rst_n),
    .path_sel_i   (sel),
    .ratio_code_i (code),
    .out_off_i    (off),
    .clk_div_o    (clk_out)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = !clk;
  end

  always @(clk_out) begin
    if (clk_out === 1'b1) begin
      nrise++;
      per_last = $realtime - rt_last;
      rt_last  = $realtime;
    end else if (clk_out === 1'b0) begin
      nfall++;
      hi_last = $realtime - rt_last;
    end
  end

  task automatic check_real(string req, realtime act, realtime exp);
    checks++;
    if (act > exp + 0.01 || act < exp - 0.01) begin
      fails++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_rise(string req);
    int n0 = nrise;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (nrise != n0) return;
    end
    check_int({req, " rise timeout"}, 0, 1);
  endtask

  task automatic wait_fall(string req);
    int n0 = nfall;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (nfall != n0) return;
    end
    check_int({req, " fall timeout"}, 0, 1);
  endtask

  task automatic measure(string req, int ratio);
    for (int i = 0; i < 3; i++) wait_rise(req);
    check_real({req, " period"}, per_last, TCK * ratio);
    wait_fall(req);
    check_real({req, " high time"}, hi_last, TCK * ratio / 2.0);
  endtask

  task automatic expect_quiet(string req);
    int n0;
    repeat (130) tick();
    n0 = nrise;
    repeat (100) tick();
    check_int({req, " rises while parked"}, nrise - n0, 0);
    check_int({req, " level while parked"}, int'(clk_out), 0);
  endtask

  initial begin
    #(200000 * TCK);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    realtime t_set;
    int base;
    rst_n = 1'b0;
    sel   = 3'b000;
    code  = 4'd5;
    off   = 1'b0;
    // R9: output low while reset is held, sampled in both clock phases
    @(posedge clk); #1;
    check_int("R9 reset clk high", int'(clk_out), 0);
    @(negedge clk); #1;
    check_int("R9 reset clk low", int'(clk_out), 0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1..R5 sweep over every path code and every programmable ratio
    for (int s = 0; s < 8; s++) begin
      if ((s & 3) == 3) begin
        for (int k = 1; k < 15; k++) begin
          sel  = 3'(s);
          code = 4'(k);
          base = 2 * k + 2;
          measure((s > 3) ? "R4 R5 prog doubled" : "R3 R5 prog", (s > 3) ? 2 * base : base);
        end
      end else begin
        sel  = 3'(s);
        code = 4'(9 - s);
        base = ((s & 3) == 0) ? 1 : (((s & 3) == 1) ? 2 : 4);
        if (s == 0)      measure("R1 direct", 1);
        else if (s < 4)  measure("R2 R5 fixed", base);
        else             measure("R4 R5 fixed doubled", 2 * base);
      end
    end

    // R8: change /4 to /30 just after a rising edge
    sel = 3'b010; code = 4'd0;
    measure("R8 setup", 4);
    wait_rise("R8");
    sel = 3'b011; code = 4'd14;
    wait_fall("R8");
    check_real("R8 old high phase kept", hi_last, TCK * 2);
    wait_rise("R8");
    check_real("R8 new low phase", per_last, TCK * 2 + TCK * 15);

    // R6: reserved ratio codes park the output
    sel = 3'b011; code = 4'd0;
    expect_quiet("R6 code 0000");
    sel = 3'b011; code = 4'd15;
    expect_quiet("R6 code 1111");
    sel = 3'b111; code = 4'd15;
    expect_quiet("R6 doubled code 1111");

    // R7: disable overrides divided and direct paths
    sel = 3'b011; code = 4'd14;
    measure("R7 setup", 30);
    off = 1'b1;
    expect_quiet("R7 off over /30");
    sel = 3'b000;
    expect_quiet("R7 off over direct");

    // R10: from parked, /6 is taken at the next edge; rise D/2 cycles later
    sel = 3'b011; code = 4'd2;
    off = 1'b0;
    t_set = $realtime;
    wait_rise("R10");
    check_real("R10 first rise delay", rt_last - t_set, TCK * 4 - 1.0);
    measure("R10 /6 after park", 6);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule